// File: doc/BRIEF.md
# Symmetric Resampling Kernel Expander

This block receives the lower half of a linear-phase resampling filter and builds the complete kernel in on-chip storage. Each storage word packs three signed 9-bit coefficients, in lanes at bits [8:0], [17:9] and [26:18]. The half kernel arrives as six packed words. The sixth word carries coefficient 15 twice, followed by a zero pad. After the sixth word, the block fills the remaining five words of the eleven-word kernel by reading its own first half back in reverse word order.

A resampling datapath reads single coefficients through a tap port. It presents a 5-bit tap index and gets back the sign-extended coefficient one cycle later. The tap port hides the layout of the storage. Taps 0 to 16 run upward through the words. The pad comes next. Taps 17 to 31 run downward, with the lane order reversed relative to the tap order.

Storage is double-banked. An upload builds the new kernel in the hidden bank and switches banks on the last write. Tap reads therefore never see a half-written kernel.

Top module: `sym_kernel_expander`

## Requirements
- R1: For tap index k in 0..14, the tap port returns lane k%3 of the k/3-th uploaded word, where lane 0 is bits [8:0], lane 1 is bits [17:9] and lane 2 is bits [26:18].
- R2: Tap 15 returns lane 0 and tap 16 returns lane 1 of the sixth uploaded word. Lane 2 of that word (the pad) is returned by no tap index.
- R3: Stored words 6..10 are copies of words 4..0. For k in 17..31, tap k returns lane (31-k)%3 of uploaded word (31-k)/3, so tap k equals tap 31-k.
- R4: A read requested in one cycle presents its coefficient in the next cycle, sign-extended from 9 bits to the output width, with tap_valid high in that cycle only. Without a request, tap_coef holds its value.
- R5: After load_start, each cycle with load_valid high accepts one word, until six are taken. load_valid is ignored while no upload is open and during the expansion cycles.
- R6: The sixth accepted word is followed by five expansion cycles. load_done is high for exactly one cycle, the cycle after the eleventh storage write, which is five cycles after the edge that takes the sixth word.
- R7: load_start in any state opens a fresh upload at word zero and abandons a partial one. A load_valid in the same cycle as load_start is ignored. An abandoned upload never raises load_done.
- R8: Tap reads sampled up to and including the edge of the eleventh write return the previously completed kernel. Reads sampled after it return the new one.
- R9: Bits [31:27] of an uploaded word have no effect on any tap value.
- R10: After reset every tap reads zero, and load_done and tap_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | Opens a new upload at word zero |
| load_valid | input | 1 | load_word carries a half-kernel word this cycle |
| load_word | input | BUS_W | Packed word of three 9-bit coefficients in bits [26:0] |
| load_done | output | 1 | One-cycle pulse when the new kernel becomes visible |
| tap_req | input | 1 | Request a coefficient read |
| tap_idx | input | IDX_W | Tap index 0..31 |
| tap_valid | output | 1 | tap_coef holds the result of last cycle's request |
| tap_coef | output | OUT_W | Sign-extended coefficient |

## Verification
Errors in the mirror addressing show up directly as wrong values on taps 17 to 31. Because the tap port reads the coefficient memory as it is stored, a bad copy is visible on the first read after load_done.

Errors in the beat counter or phase sequencing move the load_done pulse off its fixed cycle, five cycles after the sixth accepted word. A swapped bank select makes taps read during an upload change before load_done. Both faults are exposed within the same upload, because a read is issued every cycle and checked against a behavioural model.

// File: rtl/kx_pkg.sv
`timescale 1ns/1ps
package kx_pkg;

  typedef enum logic [1:0] {
    KX_IDLE   = 2'd0,
    KX_FILL   = 2'd1,
    KX_MIRROR = 2'd2
  } kx_phase_e;

  // Storage word that holds tap idx.
  function automatic int tap_word(input int idx, input int lanes, input int half_words);
    int full_words = 2 * half_words - 1;
    int low_taps   = half_words * lanes - 1;
    int taps       = full_words * lanes - 1;
    int m;
    if (idx < low_taps) return idx / lanes;
    m = taps - 1 - idx;
    return full_words - 1 - m / lanes;
  endfunction

  // Lane inside that word.
  function automatic int tap_lane(input int idx, input int lanes, input int half_words);
    int full_words = 2 * half_words - 1;
    int low_taps   = half_words * lanes - 1;
    int taps       = full_words * lanes - 1;
    if (idx < low_taps) return idx % lanes;
    return (taps - 1 - idx) % lanes;
  endfunction

endpackage

// File: rtl/kx_load_seq.sv
`timescale 1ns/1ps
module kx_load_seq #(
  parameter int HALF_WORDS = 6,
  parameter int FULL_WORDS = 11,
  parameter int AW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_mirror,
  output logic [AW-1:0] mirror_addr,
  output logic          commit
);
  import kx_pkg::*;

  kx_phase_e     phase;
  logic [AW-1:0] cnt;

  always_comb begin
    wr_addr     = cnt;
    wr_mirror   = (phase == KX_MIRROR);
    mirror_addr = AW'(FULL_WORDS - 1) - cnt;
    wr_en       = !start && ((phase == KX_FILL && valid) || phase == KX_MIRROR);
    commit      = !start && phase == KX_MIRROR && cnt == AW'(FULL_WORDS - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= KX_IDLE;
      cnt   <= '0;
    end else if (start) begin
      phase <= KX_FILL;
      cnt   <= '0;
    end else begin
      case (phase)
        KX_FILL: if (valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(HALF_WORDS - 1)) phase <= KX_MIRROR;
        end
        KX_MIRROR: begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(FULL_WORDS - 1)) phase <= KX_IDLE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/kx_bank_store.sv
`timescale 1ns/1ps
module kx_bank_store #(
  parameter int FULL_WORDS = 11,
  parameter int STORE_W    = 27,
  parameter int AW         = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic               wr_mirror,
  input  logic [AW-1:0]      mirror_addr,
  input  logic [STORE_W-1:0] wr_data_in,
  input  logic               commit,
  input  logic [AW-1:0]      rd_addr,
  output logic [STORE_W-1:0] rd_word
);
  logic [STORE_W-1:0] bank [2][FULL_WORDS];
  logic               live;
  logic               shadow;
  logic [STORE_W-1:0] wdata;

  assign shadow  = ~live;
  assign wdata   = wr_mirror ? bank[shadow][mirror_addr] : wr_data_in;
  assign rd_word = bank[live][rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < FULL_WORDS; w++)
          bank[b][w] <= '0;
    end else begin
      if (wr_en) bank[shadow][wr_addr] <= wdata;
      if (commit) live <= shadow;
    end
  end

endmodule

// File: rtl/kx_tap_unpack.sv
`timescale 1ns/1ps
module kx_tap_unpack #(
  parameter int LANES   = 3,
  parameter int COEF_W  = 9,
  parameter int OUT_W   = 16,
  parameter int LW      = 2,
  localparam int STORE_W = LANES * COEF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [LW-1:0]      lane_sel,
  input  logic [STORE_W-1:0] word,
  output logic               tap_valid,
  output logic [OUT_W-1:0]   tap_coef
);
  logic [COEF_W-1:0] lane_v [LANES];
  logic [COEF_W-1:0] pick;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_v[g] = word[g*COEF_W +: COEF_W];
  end

  assign pick = lane_v[lane_sel];

  function automatic logic [OUT_W-1:0] sext(input logic [COEF_W-1:0] v);
    return {{(OUT_W-COEF_W){v[COEF_W-1]}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_valid <= 1'b0;
      tap_coef  <= '0;
    end else begin
      tap_valid <= req;
      if (req) tap_coef <= sext(pick);
    end
  end

endmodule

// File: rtl/sym_kernel_expander.sv
`timescale 1ns/1ps
module sym_kernel_expander #(
  parameter int HALF_WORDS = 6,
  parameter int LANES      = 3,
  parameter int COEF_W     = 9,
  parameter int BUS_W      = 32,
  parameter int OUT_W      = 16,
  localparam int FULL_WORDS = 2 * HALF_WORDS - 1,
  localparam int TAPS       = FULL_WORDS * LANES - 1,
  localparam int IDX_W      = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic             load_valid,
  input  logic [BUS_W-1:0] load_word,
  output logic             load_done,
  input  logic             tap_req,
  input  logic [IDX_W-1:0] tap_idx,
  output logic             tap_valid,
  output logic [OUT_W-1:0] tap_coef
);
  localparam int STORE_W = LANES * COEF_W;
  localparam int AW      = $clog2(FULL_WORDS);
  localparam int LW      = $clog2(LANES);

  // Named internal events, also observed by the bound checker.
  logic               wr_en_evt;
  logic [AW-1:0]      wr_addr_evt;
  logic               wr_mirror_evt;
  logic [AW-1:0]      mirror_addr;
  logic               commit_evt;
  logic [AW-1:0]      rd_word_idx;
  logic [LW-1:0]      rd_lane_idx;
  logic [STORE_W-1:0] rd_word;
  logic               unused_hi;

  assign unused_hi = ^load_word[BUS_W-1:STORE_W];

  always_comb begin
    rd_word_idx = AW'(kx_pkg::tap_word(int'(tap_idx), LANES, HALF_WORDS));
    rd_lane_idx = LW'(kx_pkg::tap_lane(int'(tap_idx), LANES, HALF_WORDS));
  end

  kx_load_seq #(.HALF_WORDS(HALF_WORDS), .FULL_WORDS(FULL_WORDS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(load_start), .valid(load_valid),
    .wr_en(wr_en_evt), .wr_addr(wr_addr_evt), .wr_mirror(wr_mirror_evt),
    .mirror_addr(mirror_addr), .commit(commit_evt)
  );

  kx_bank_store #(.FULL_WORDS(FULL_WORDS), .STORE_W(STORE_W), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_evt), .wr_addr(wr_addr_evt),
    .wr_mirror(wr_mirror_evt), .mirror_addr(mirror_addr),
    .wr_data_in(load_word[STORE_W-1:0]), .commit(commit_evt),
    .rd_addr(rd_word_idx), .rd_word(rd_word)
  );

  kx_tap_unpack #(.LANES(LANES), .COEF_W(COEF_W), .OUT_W(OUT_W), .LW(LW)) u_unpack (
    .clk(clk), .rst_n(rst_n), .req(tap_req), .lane_sel(rd_lane_idx),
    .word(rd_word), .tap_valid(tap_valid), .tap_coef(tap_coef)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_done <= 1'b0;
    else        load_done <= commit_evt;
  end

endmodule

// File: rtl/kx_expander_chk.sv
`timescale 1ns/1ps
module kx_expander_chk #(
  parameter int HALF_WORDS = 6,
  parameter int COEF_W     = 9,
  parameter int OUT_W      = 16,
  parameter int AW         = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_start,
  input logic             load_done,
  input logic             tap_req,
  input logic             tap_valid,
  input logic [OUT_W-1:0] tap_coef,
  input logic             commit_evt,
  input logic             wr_en_evt,
  input logic             wr_mirror_evt,
  input logic [AW-1:0]    wr_addr_evt
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  // R6
  commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> load_done);

  // R7
  start_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !load_done);

  // R4
  tap_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_req |=> tap_valid);

  // R4
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_req |=> (!tap_valid && $stable(tap_coef)));

  // R4
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid |-> ($countones(tap_coef[OUT_W-1:COEF_W-1]) == 0 ||
                   $countones(tap_coef[OUT_W-1:COEF_W-1]) == OUT_W - COEF_W + 1));

  // R3
  mirror_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_evt && wr_mirror_evt) |-> (wr_addr_evt >= AW'(HALF_WORDS)));

  // R5
  fill_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_evt && !wr_mirror_evt) |-> (wr_addr_evt < AW'(HALF_WORDS)));

endmodule

bind sym_kernel_expander kx_expander_chk #(
  .HALF_WORDS(HALF_WORDS), .COEF_W(COEF_W), .OUT_W(OUT_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_done(load_done),
  .tap_req(tap_req), .tap_valid(tap_valid), .tap_coef(tap_coef),
  .commit_evt(commit_evt), .wr_en_evt(wr_en_evt),
  .wr_mirror_evt(wr_mirror_evt), .wr_addr_evt(wr_addr_evt)
);

// File: tb/sym_kernel_expander_test.sv
`timescale 1ns/1ps
module sym_kernel_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0;
  logic        load_valid = 1'b0;
  logic [31:0] load_word = '0;
  logic        load_done;
  logic        tap_req = 1'b0;
  logic [4:0]  tap_idx = '0;
  logic        tap_valid;
  logic [15:0] tap_coef;

  always #10 clk = ~clk;

  sym_kernel_expander uut (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_valid(load_valid),
    .load_word(load_word), .load_done(load_done), .tap_req(tap_req),
    .tap_idx(tap_idx), .tap_valid(tap_valid), .tap_coef(tap_coef)
  );

  int    checks = 0;
  int    errors = 0;
  bit    checking = 0;
  bit    finished = 0;

  // Behavioural reference model
  logic [26:0] cur [6];
  logic [26:0] q [$];
  int          phase = 0;  // 0 no upload, 1 taking words, 2 expanding
  int          nexp = 0;
  logic        exp_done = 0, exp_valid = 0;
  logic [15:0] exp_coef = '0;
  string       exp_tag = "R10";

  function automatic logic [15:0] ref_tap(input logic [26:0] hw [6], input int k);
    logic [26:0] fw [11];
    logic [8:0]  slot [33];
    logic [8:0]  back [15];
    logic [8:0]  v;
    int n = 0;
    for (int i = 0; i < 11; i++) fw[i] = (i < 6) ? hw[i] : hw[10 - i];
    for (int w = 0; w < 11; w++)
      for (int l = 0; l < 3; l++) slot[w*3 + l] = fw[w][l*9 +: 9];
    for (int w = 10; w >= 6; w--)
      for (int l = 0; l < 3; l++) begin back[n] = slot[w*3 + l]; n++; end
    v = (k < 17) ? slot[k] : back[31 - k];
    return {{7{v[8]}}, v};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) cur[i] = '0;
      q.delete(); phase = 0; nexp = 0;
      exp_done = 0; exp_valid = 0; exp_coef = '0;
    end else begin
      exp_valid = tap_req;
      if (tap_req) begin
        exp_coef = ref_tap(cur, int'(tap_idx));
        if (phase != 0)          exp_tag = "R8";
        else if (tap_idx < 15)   exp_tag = "R1";
        else if (tap_idx < 17)   exp_tag = "R2";
        else                     exp_tag = "R3";
      end
      exp_done = 0;
      if (load_start) begin
        phase = 1; q.delete();
      end else if (phase == 1 && load_valid) begin
        q.push_back(load_word[26:0]);
        if (q.size() == 6) begin phase = 2; nexp = 0; end
      end else if (phase == 2) begin
        nexp++;
        if (nexp == 5) begin
          for (int i = 0; i < 6; i++) cur[i] = q[i];
          phase = 0; exp_done = 1;
        end
      end
    end
  end

  task automatic compare();
    if (!checking) return;
    checks += 3;
    if (load_done !== exp_done) begin
      errors++;
      $display("FAIL R6 load_done actual %b expected %b", load_done, exp_done);
    end
    if (tap_valid !== exp_valid) begin
      errors++;
      $display("FAIL R4 tap_valid actual %b expected %b", tap_valid, exp_valid);
    end
    if (tap_coef !== exp_coef) begin
      errors++;
      $display("FAIL %s tap_coef actual %h expected %h", exp_tag, tap_coef, exp_coef);
    end
  endtask

  task automatic cyc(input logic s, input logic v, input logic [31:0] w,
                     input logic r, input logic [4:0] i);
    @(negedge clk);
    compare();
    load_start = s; load_valid = v; load_word = w; tap_req = r; tap_idx = i;
  endtask

  // Three signed lanes plus junk in bits [31:27] (R9)
  function automatic logic [31:0] mkword(input int seed, input int i);
    logic [31:0] w;
    w[31:27] = 5'(seed * 11 + i + 17);
    for (int l = 0; l < 3; l++) w[l*9 +: 9] = 9'(seed * 53 + (i*3 + l) * 41 - 230);
    return w;
  endfunction

  int rd = 0;
  task automatic beat(input logic s, input logic v, input logic [31:0] w);
    cyc(s, v, w, 1'b1, 5'(rd));
    rd = (rd + 7) % 32;
  endtask

  task automatic upload(input int seed, input int gap);
    beat(1'b1, 1'b0, '0);
    for (int i = 0; i < 6; i++) begin
      beat(1'b0, 1'b1, mkword(seed, i));
      for (int g = 0; g < gap; g++) beat(1'b0, 1'b0, 32'hDEAD_BEEF);
    end
    // R5: valid during expansion is ignored
    for (int e = 0; e < 5; e++) beat(1'b0, 1'b1, 32'hFFFF_FFFF);
    // R6: done lands in the following cycle
    beat(1'b0, 1'b0, '0);
  endtask

  task automatic sweep();
    for (int k = 0; k < 32; k++) cyc(1'b0, 1'b0, '0, 1'b1, 5'(k));
    cyc(1'b0, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checking = 1;
    // R10: reset state, all taps zero
    sweep();
    // R5: valid with no upload open is ignored
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 32'h07FF_FFFF, 1'b1, 5'(i * 9));
    sweep();
    // R1 R2 R3 R9: upload with gaps, then read every tap
    upload(1, 1);
    sweep();
    // R8: back-to-back upload, reads run against the older kernel
    upload(2, 0);
    sweep();
    // R7: abandon after three words, restart at word zero
    beat(1'b1, 1'b0, '0);
    for (int i = 0; i < 3; i++) beat(1'b0, 1'b1, mkword(9, i));
    beat(1'b1, 1'b1, mkword(9, 3));
    for (int i = 0; i < 6; i++) beat(1'b0, 1'b1, mkword(3, i));
    for (int e = 0; e < 6; e++) beat(1'b0, 1'b0, '0);
    sweep();
    // R7: restart in the middle of expansion, no done pulse
    beat(1'b1, 1'b0, '0);
    for (int i = 0; i < 6; i++) beat(1'b0, 1'b1, mkword(5, i));
    beat(1'b0, 1'b0, '0);
    beat(1'b0, 1'b0, '0);
    upload(4, 2);
    sweep();
    // R6: restart on the commit cycle itself
    beat(1'b1, 1'b0, '0);
    for (int i = 0; i < 6; i++) beat(1'b0, 1'b1, mkword(6, i));
    for (int e = 0; e < 4; e++) beat(1'b0, 1'b0, '0);
    beat(1'b1, 1'b0, '0);
    for (int i = 0; i < 8; i++) beat(1'b0, 1'b0, '0);
    sweep();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule